// File: doc/BRIEF.md
# Prioritised Chip-Select Region Decoder

This block sits between an internal bus and an external bus controller. Each request carries an address, a read/write flag, an access size and a burst flag. The block compares the request against a set of programmable chip-select regions. Each region has its own base, mask, enable, bus width (16 or 32 bits), write-protect bit and byte-order bit. The block picks the highest-priority region that accepts the access. If no region accepts it, the block reports an error.

A write that lands on a write-protected region is not refused outright. Instead it falls through to the next lower-priority region that also matches the address and permits writes. Big-endian byte order is supported only for single accesses to 16-bit regions, and it is done by rewriting the two low address bits. A burst request that selects such a region is rejected. The chosen region index, the address after translation and the error flag are registered. They reach the external cycle sequencer one clock after the request, qualified by a valid strobe.

Top module: `rgn_decoder`

## Requirements
- R1: A region matches when it is enabled and (req_addr & mask) equals (base & mask). Among the regions that accept the request, the one with the lowest index is reported in rsp_region, and rsp_hit is 1.
- R2: A region whose enable bit is 0 is never selected, even if its address compare matches.
- R3: A write (req_write=1) to a matching region whose write-protect bit is 1 skips that region. Selection continues with lower-priority regions. Reads ignore the write-protect bit.
- R4: When no region accepts the request, rsp_err is 1, rsp_hit is 0 and rsp_region is 0. rsp_err and rsp_hit are never both 1, and never both 0, while rsp_valid is 1.
- R5: For a selected region whose byte-order bit is 0 (little-endian), rsp_addr equals req_addr. For a selected region whose width bit is 1 (32-bit), rsp_addr also equals req_addr, whatever its byte-order bit.
- R6: For a single access to a selected region with byte-order bit 1 and width bit 0, the address is translated. With req_size 00 (8-bit), address bits [1:0] are inverted. With req_size 01 (16-bit), bit 1 is inverted. With req_size 10 (32-bit), the address is unchanged. Bits above bit 1 are never altered.
- R7: A burst request (req_burst=1) whose selected region has byte-order bit 1 and width bit 0 yields rsp_err=1, rsp_hit=0, rsp_region=0, and rsp_addr equal to req_addr. A burst to a 32-bit region is accepted normally.
- R8: rsp_valid is req_valid delayed by exactly one clock. The response fields are captured in the same edge. An active-low reset clears rsp_valid, rsp_hit and rsp_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | NREG*AW | Region base addresses, region i in bits [i*AW +: AW] |
| cfg_mask | input | NREG*AW | Region compare masks, same packing |
| cfg_en | input | NREG | Region enable bits |
| cfg_wide32 | input | NREG | Region width: 1 = 32-bit, 0 = 16-bit |
| cfg_wprot | input | NREG | Region write-protect bits |
| cfg_bigend | input | NREG | Region byte order: 1 = big-endian |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 = 8-bit, 01 = 16-bit, 10 = 32-bit |
| req_burst | input | 1 | 1 = burst request |
| rsp_valid | output | 1 | Response strobe, one clock after req_valid |
| rsp_hit | output | 1 | A region was selected |
| rsp_region | output | IW | Index of the selected region |
| rsp_addr | output | AW | Address after byte-order translation |
| rsp_err | output | 1 | No region accepted the request |

## Verification
All four regions are programmed together so that their windows overlap. This lets a single address produce a different winner depending on read versus write and on the enable bits, which separates priority order from write-protect fall-through and from the enable gate. Every low-address pattern is applied at each access size to the big-endian 16-bit region. Comparing those results with the same patterns on little-endian and 32-bit regions separates translation from pass-through. Burst requests are sent to both a big-endian 16-bit region and a big-endian-flagged 32-bit region, which shows that the rejection depends on the region width. Addresses outside every window, and protected writes with no fallback region, cover the error path.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } acc_size_e;

endpackage

// File: rtl/rgn_match.sv
module rgn_match #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr,
   input  logic          is_write,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] mask,
   input  logic          en,
   input  logic          wprot,
   output logic          accept
);

   logic hit_window;

   always_comb begin
      hit_window = ((addr & mask) == (base & mask));
      accept     = en && hit_window && !(is_write && wprot);
   end

endmodule

// File: rtl/rgn_prio.sv
module rgn_prio #(
   parameter int NREG = 4,
   parameter int IW   = 2
) (
   input  logic [NREG-1:0] accept,
   output logic [IW-1:0]   win_idx,
   output logic            win_any
);

   logic [NREG-1:0] grant;

   always_comb begin
      grant   = '0;
      win_idx = '0;
      win_any = 1'b0;
      for (int i = 0; i < NREG; i++) begin
         if (accept[i] && !win_any) begin
            win_any  = 1'b1;
            win_idx  = IW'(i);
            grant[i] = 1'b1;
         end
      end
   end

   always_comb begin
      AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R1
      AST_GRANT_ACCEPTED: assert ((grant & ~accept) == '0); // R2
   end

endmodule

// File: rtl/rgn_swizzle.sv
module rgn_swizzle
   import rgn_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr_in,
   input  logic [1:0]    size,
   input  logic          swap_en,
   output logic [AW-1:0] addr_out
);

   logic [1:0] flip;

   always_comb begin
      flip = 2'b00;
      if (swap_en) begin
         unique case (size)
            SZ_BYTE: flip = 2'b11;
            SZ_HALF: flip = 2'b10;
            default: flip = 2'b00;
         endcase
      end
      addr_out = {addr_in[AW-1:2], addr_in[1:0] ^ flip};
   end

   always_comb begin
      AST_UPPER_KEPT: assert (addr_out[AW-1:2] == addr_in[AW-1:2]); // R6
   end

endmodule

// File: rtl/rgn_decoder.sv
module rgn_decoder #(
   parameter int AW   = 32,
   parameter int NREG = 4,
   localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NREG*AW-1:0]   cfg_base,
   input  logic [NREG*AW-1:0]   cfg_mask,
   input  logic [NREG-1:0]      cfg_en,
   input  logic [NREG-1:0]      cfg_wide32,
   input  logic [NREG-1:0]      cfg_wprot,
   input  logic [NREG-1:0]      cfg_bigend,
   input  logic                 req_valid,
   input  logic [AW-1:0]        req_addr,
   input  logic                 req_write,
   input  logic [1:0]           req_size,
   input  logic                 req_burst,
   output logic                 rsp_valid,
   output logic                 rsp_hit,
   output logic [IW-1:0]        rsp_region,
   output logic [AW-1:0]        rsp_addr,
   output logic                 rsp_err
);

   generate
      if (AW < 3) begin : g_bad_aw
         $error("rgn_decoder: AW must be at least 3");
      end
      if (NREG < 1 || NREG > 16) begin : g_bad_nreg
         $error("rgn_decoder: NREG must be in 1..16");
      end
   endgenerate

   logic [NREG-1:0] accept;
   logic [IW-1:0]   win_idx;
   logic            win_any;
   logic            sel_be16;
   logic            burst_reject;
   logic            hit_d;
   logic [AW-1:0]   addr_d;

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_region
         rgn_match #(.AW(AW)) u_match (
            .addr     (req_addr),
            .is_write (req_write),
            .base     (cfg_base[g*AW +: AW]),
            .mask     (cfg_mask[g*AW +: AW]),
            .en       (cfg_en[g]),
            .wprot    (cfg_wprot[g]),
            .accept   (accept[g])
         );
      end
   endgenerate

   rgn_prio #(.NREG(NREG), .IW(IW)) u_prio (
      .accept  (accept),
      .win_idx (win_idx),
      .win_any (win_any)
   );

   always_comb begin
      sel_be16     = win_any && cfg_bigend[win_idx] && !cfg_wide32[win_idx];
      burst_reject = sel_be16 && req_burst;
      hit_d        = win_any && !burst_reject;
   end

   rgn_swizzle #(.AW(AW)) u_swz (
      .addr_in  (req_addr),
      .size     (req_size),
      .swap_en  (sel_be16 && !req_burst),
      .addr_out (addr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_err    <= 1'b0;
         rsp_region <= '0;
         rsp_addr   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit    <= hit_d;
            rsp_err    <= !hit_d;
            rsp_region <= hit_d ? win_idx : '0;
            rsp_addr   <= addr_d;
         end
      end
   end

   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R8
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R8
   AST_ERR_XOR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_err != rsp_hit)); // R4
   AST_ERR_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_region == '0)); // R4
   AST_BURST_BE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_burst && sel_be16) |=> (rsp_err && !rsp_hit)); // R7

endmodule

// File: tb/rgn_decoder_tb.sv
module rgn_decoder_tb;
   localparam int AW   = 32;
   localparam int NREG = 4;
   localparam int IW   = 2;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NREG*AW-1:0]  cfg_base, cfg_mask;
   logic [NREG-1:0]     cfg_en, cfg_wide32, cfg_wprot, cfg_bigend;
   logic                req_valid = 1'b0;
   logic [AW-1:0]       req_addr = '0;
   logic                req_write = 1'b0;
   logic [1:0]          req_size = 2'b00;
   logic                req_burst = 1'b0;
   logic                rsp_valid, rsp_hit, rsp_err;
   logic [IW-1:0]       rsp_region;
   logic [AW-1:0]       rsp_addr;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   rgn_decoder #(.AW(AW), .NREG(NREG)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
      .cfg_wide32(cfg_wide32), .cfg_wprot(cfg_wprot), .cfg_bigend(cfg_bigend),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_size(req_size), .req_burst(req_burst),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_region(rsp_region),
      .rsp_addr(rsp_addr), .rsp_err(rsp_err)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic        wr;
      logic [1:0]  size;
      logic        burst;
      logic        hit;
      logic [1:0]  reg_i;
      logic [31:0] xaddr;
      logic        err;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{32'h1000_0000, 1'b0, 2'b00, 1'b0, 1'b1, 2'd0, 32'h1000_0003, 1'b0, 8'd6},
      '{32'h1000_0001, 1'b0, 2'b00, 1'b0, 1'b1, 2'd0, 32'h1000_0002, 1'b0, 8'd6},
      '{32'h1000_0002, 1'b0, 2'b00, 1'b0, 1'b1, 2'd0, 32'h1000_0001, 1'b0, 8'd6},
      '{32'h1000_0003, 1'b0, 2'b00, 1'b0, 1'b1, 2'd0, 32'h1000_0000, 1'b0, 8'd6},
      '{32'h1000_0000, 1'b0, 2'b01, 1'b0, 1'b1, 2'd0, 32'h1000_0002, 1'b0, 8'd6},
      '{32'h1000_0006, 1'b0, 2'b01, 1'b0, 1'b1, 2'd0, 32'h1000_0004, 1'b0, 8'd6},
      '{32'h1000_0004, 1'b0, 2'b10, 1'b0, 1'b1, 2'd0, 32'h1000_0004, 1'b0, 8'd6},
      '{32'h1000_0008, 1'b1, 2'b00, 1'b0, 1'b1, 2'd0, 32'h1000_000B, 1'b0, 8'd6},
      '{32'h1000_0000, 1'b0, 2'b10, 1'b1, 1'b0, 2'd0, 32'h1000_0000, 1'b1, 8'd7},
      '{32'h2000_0004, 1'b0, 2'b00, 1'b0, 1'b1, 2'd1, 32'h2000_0004, 1'b0, 8'd1},
      '{32'h2100_0005, 1'b0, 2'b00, 1'b0, 1'b1, 2'd2, 32'h2100_0005, 1'b0, 8'd5},
      '{32'h2000_0004, 1'b1, 2'b01, 1'b0, 1'b1, 2'd2, 32'h2000_0004, 1'b0, 8'd3},
      '{32'h3000_0000, 1'b1, 2'b10, 1'b0, 1'b0, 2'd0, 32'h3000_0000, 1'b1, 8'd4},
      '{32'h3000_0001, 1'b0, 2'b00, 1'b0, 1'b1, 2'd3, 32'h3000_0001, 1'b0, 8'd5},
      '{32'h3000_0000, 1'b0, 2'b10, 1'b1, 1'b1, 2'd3, 32'h3000_0000, 1'b0, 8'd7},
      '{32'h4000_0000, 1'b0, 2'b00, 1'b0, 1'b0, 2'd0, 32'h4000_0000, 1'b1, 8'd4}
   };

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] a, input logic w, input logic [1:0] s,
                        input logic b);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = w; req_size = s; req_burst = b;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string rq, input logic hit, input logic [1:0] ri,
                             input logic [31:0] xa, input logic err);
      logic [63:0] act, exp;
      act = {27'd0, rsp_valid, rsp_hit, rsp_region, rsp_err, rsp_addr};
      exp = {27'd0, 1'b1, hit, ri, err, xa};
      check(act == exp, rq, "{valid,hit,region,err,addr}", act, exp);
   endtask

   initial begin
      cfg_base   = {32'h3000_0000, 32'h2000_0000, 32'h2000_0000, 32'h1000_0000};
      cfg_mask   = {32'hF000_0000, 32'hF000_0000, 32'hFFF0_0000, 32'hF000_0000};
      cfg_en     = 4'b1111;
      cfg_wide32 = 4'b1010;
      cfg_wprot  = 4'b1010;
      cfg_bigend = 4'b1001;
      repeat (3) @(negedge clk);
      // R8: reset state
      check(rsp_valid == 1'b0 && rsp_hit == 1'b0 && rsp_err == 1'b0, "R8",
            "reset outputs", {61'd0, rsp_valid, rsp_hit, rsp_err}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R8", "idle valid", {63'd0, rsp_valid}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i].addr, VEC[i].wr, VEC[i].size, VEC[i].burst);
         expect_rsp($sformatf("R%0d", VEC[i].req), VEC[i].hit, VEC[i].reg_i,
                    VEC[i].xaddr, VEC[i].err);
      end

      // R8: valid drops one cycle after request ends
      @(negedge clk);
      check(rsp_valid == 1'b0, "R8", "valid after idle", {63'd0, rsp_valid}, 64'd0);

      // R2: disabled region 1 is skipped, region 2 wins
      cfg_en = 4'b1101;
      issue(32'h2000_0004, 1'b0, 2'b00, 1'b0);
      expect_rsp("R2", 1'b1, 2'd2, 32'h2000_0004, 1'b0);

      // R2: disabled matching region 0 makes its window an error
      cfg_en = 4'b1110;
      issue(32'h1000_0000, 1'b0, 2'b00, 1'b0);
      expect_rsp("R2", 1'b0, 2'd0, 32'h1000_0000, 1'b1);

      // R3: unprotected region 1 now wins a write
      cfg_en = 4'b1111; cfg_wprot = 4'b1000;
      issue(32'h2000_0004, 1'b1, 2'b10, 1'b0);
      expect_rsp("R3", 1'b1, 2'd1, 32'h2000_0004, 1'b0);

      // R5: region 0 switched to little-endian passes address through
      cfg_bigend = 4'b1000;
      issue(32'h1000_0001, 1'b0, 2'b00, 1'b0);
      expect_rsp("R5", 1'b1, 2'd0, 32'h1000_0001, 1'b0);

      // R7: burst to little-endian 16-bit region is accepted
      issue(32'h1000_0000, 1'b0, 2'b10, 1'b1);
      expect_rsp("R7", 1'b1, 2'd0, 32'h1000_0000, 1'b0);

      // R8: reset mid-stream clears valid
      @(negedge clk);
      req_valid = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      check(rsp_valid == 1'b0 && rsp_hit == 1'b0 && rsp_err == 1'b0, "R8",
            "reset clears", {61'd0, rsp_valid, rsp_hit, rsp_err}, 64'd0);
      req_valid = 1'b0;

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule